// File: doc/BRIEF.md
# Booth-Recoded Signed Weight Multiplier

This block multiplies a signed input sample by a signed filter weight without using a hardware multiplier. The weight is recoded into signed Booth digits. By default each digit covers three weight bits and takes values from −4 to +4. A parameter switches the recoding to digits that each cover two weight bits and take values from −2 to +2. Each digit selects a shifted or pre-added copy of the sample, which is negated when the digit is negative. The copy is then placed at the digit's bit weight. The resulting rows are compressed by layers of 3:2 carry-save adders until two remain, and a final carry-propagate add produces the product.

A second parameter drops every partial-product bit below a chosen position, which trades accuracy for area. The result then never exceeds the exact product and stays below it by no more than a fixed bound. Operands are presented with a valid strobe, and the product appears in an output register one clock later with its own valid flag. This suits a time-shared multiply-accumulate datapath in an adaptive filter.

Top module: `booth_wmul`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `prod_o` is 0.
- R2: When `in_valid` is 1 at a rising clock edge, `out_valid` is 1 after that edge and `prod_o` holds the product of the operands captured at that edge. When `in_valid` is 0 at an edge, `out_valid` is 0 after it.
- R3: When `in_valid` is 0 at an edge, `prod_o` keeps its previous value, whatever values `x_i` and `w_i` carry.
- R4: With RADIX=8 and TRUNC=0, `prod_o` equals the exact signed product x·w, read as a PW-bit two's-complement number with PW = XW+WW. Digit j is −4·b(3j+2) + 2·b(3j+1) + b(3j) + b(3j−1), where b(−1) = 0. There are ceil(WW/3) digits.
- R5: With RADIX=4 and TRUNC=0, `prod_o` equals the exact signed product. Digit j is −2·b(2j+1) + b(2j) + b(2j−1), which lies in {−2..2}. There are ceil(WW/2) digits.
- R6: The weight is sign-extended to a whole number of digits. This makes the product exact at the extremes, including the most negative sample, the most negative weight, and their combination.
- R7: With TRUNC=K>0, the difference (exact − `prod_o`) taken modulo 2^PW lies between 0 and (ND+1)·(2^K−1) inclusive, where ND is the digit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `x_i`/`w_i` are accepted at this edge |
| x_i | input | XW | Signed input sample (multiplicand) |
| w_i | input | WW | Signed weight, Booth-recoded (multiplier) |
| out_valid | output | 1 | `prod_o` holds a product accepted at the previous edge |
| prod_o | output | XW+WW | Registered signed product |

## Verification
The embedded checks assume that `x_i` and `w_i` are fully driven, two-state values whenever reset is released. The exact-product and error-bound checks are combinational on the operand pins. The bench therefore drives defined operands from time zero and changes them only on falling edges. The stimulus sweeps every operand pair of a 6-bit by 6-bit configuration, so every digit code and every sign-extension case is covered. Idle cycles with changed operands are inserted between the pairs to exercise the hold behaviour.

// File: rtl/booth_wmul_pkg.sv
package booth_wmul_pkg;

  // Signed Booth digit: magnitude 0..4 and a negate flag
  typedef struct packed {
    logic       neg;
    logic [2:0] mag;
  } digit_t;

  // Three-bit-step digit from a 4-bit window {b(3j+2), b(3j+1), b(3j), b(3j-1)}
  function automatic digit_t enc_tri(input logic [3:0] win);
    digit_t d;
    int v;
    v = -4 * int'(win[3]) + 2 * int'(win[2]) + int'(win[1]) + int'(win[0]);
    d.neg = (v < 0);
    d.mag = 3'((v < 0) ? -v : v);
    return d;
  endfunction

  // Two-bit-step digit from a 3-bit window {b(2j+1), b(2j), b(2j-1)}
  function automatic digit_t enc_duo(input logic [2:0] win);
    digit_t d;
    int v;
    v = -2 * int'(win[2]) + int'(win[1]) + int'(win[0]);
    d.neg = (v < 0);
    d.mag = 3'((v < 0) ? -v : v);
    return d;
  endfunction

  function automatic int digit_count(input int width, input int step);
    return (width + step - 1) / step;
  endfunction

endpackage

// File: rtl/booth_wmul_recoder.sv
module booth_wmul_recoder
  import booth_wmul_pkg::*;
#(
  parameter int WW    = 6,
  parameter int RADIX = 8,
  localparam int RB   = (RADIX == 8) ? 3 : 2,
  localparam int ND   = digit_count(WW, RB)
) (
  input  logic [WW-1:0]         w_i,
  output digit_t [ND-1:0]       dig_o
);

  localparam int EW   = RB * ND;
  localparam int MAXM = (RADIX == 8) ? 4 : 2;

  // weight sign-extended to a whole number of digits, with a zero below bit 0
  logic [EW:0] wext;
  assign wext = {{(EW - WW + 1){w_i[WW-1]}}, w_i[WW-2:0], 1'b0};

  for (genvar j = 0; j < ND; j++) begin : g_dig
    if (RADIX == 8) begin : g_tri
      assign dig_o[j] = enc_tri(wext[RB*j+3:RB*j]);
    end else begin : g_duo
      assign dig_o[j] = enc_duo(wext[RB*j+2:RB*j]);
    end

    always_comb begin
      // R4
      dig_range_chk: assert (dig_o[j].mag <= 3'(MAXM) && !(dig_o[j].neg && dig_o[j].mag == 3'd0))
        else $error("digit %0d out of range", j);
    end
  end

endmodule

// File: rtl/booth_wmul_ppgen.sv
module booth_wmul_ppgen
  import booth_wmul_pkg::*;
#(
  parameter int XW    = 6,
  parameter int PW    = 12,
  parameter int ND    = 2,
  parameter int RB    = 3,
  parameter int TRUNC = 0,
  localparam int NR   = ND + 1
) (
  input  logic [XW-1:0]          x_i,
  input  digit_t [ND-1:0]        dig_i,
  output logic [NR-1:0][PW-1:0]  rows_o
);

  localparam logic [PW-1:0] KEEP = {PW{1'b1}} << TRUNC;

  logic [PW-1:0] x1, x2, x3, x4, corr;

  // sample multiples: only the 3x needs an adder, formed once per operation
  assign x1 = {{(PW-XW){x_i[XW-1]}}, x_i};
  assign x2 = x1 << 1;
  assign x3 = x2 + x1;
  assign x4 = x1 << 2;

  for (genvar j = 0; j < ND; j++) begin : g_pp
    logic [PW-1:0] mult, inv;
    always_comb begin
      unique case (dig_i[j].mag)
        3'd1:    mult = x1;
        3'd2:    mult = x2;
        3'd3:    mult = x3;
        3'd4:    mult = x4;
        default: mult = '0;
      endcase
    end
    assign inv       = mult ^ {PW{dig_i[j].neg}};
    assign rows_o[j] = (inv << (RB*j)) & KEEP;
  end

  // +1 corrections of the negated rows, each at its digit's weight
  always_comb begin
    corr = '0;
    for (int j = 0; j < ND; j++) corr[RB*j] = dig_i[j].neg;
  end
  assign rows_o[ND] = corr & KEEP;

endmodule

// File: rtl/booth_wmul_csa_tree.sv
module booth_wmul_csa_tree #(
  parameter int PW = 12,
  parameter int NR = 3
) (
  input  logic [NR-1:0][PW-1:0] rows_i,
  output logic [PW-1:0]         sum_o,
  output logic [PW-1:0]         carry_o
);

  logic [PW-1:0] cur [NR];
  logic [PW-1:0] nxt [NR];

  // layers of 3:2 compressors until two rows remain
  always_comb begin
    int n;
    int m;
    for (int i = 0; i < NR; i++) cur[i] = rows_i[i];
    for (int i = 0; i < NR; i++) nxt[i] = '0;
    n = NR;
    for (int s = 0; s < NR; s++) begin
      if (n > 2) begin
        for (int i = 0; i < NR; i++) nxt[i] = '0;
        m = 0;
        for (int g = 0; g < NR / 3; g++) begin
          if (3*g + 2 < n) begin
            nxt[m]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[m+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                        (cur[3*g+1] & cur[3*g+2])) << 1;
            m = m + 2;
          end
        end
        for (int i = 0; i < NR; i++) begin
          if (i >= 3*(n/3) && i < n) begin
            nxt[m] = cur[i];
            m = m + 1;
          end
        end
        for (int i = 0; i < NR; i++) cur[i] = nxt[i];
        n = m;
      end
    end
    sum_o   = cur[0];
    carry_o = (n > 1) ? cur[1] : '0;
  end

  logic [PW-1:0] row_total;
  always_comb begin
    row_total = '0;
    for (int i = 0; i < NR; i++) row_total = row_total + rows_i[i];
  end

  always_comb begin
    // R4
    tree_sum_chk: assert (sum_o + carry_o == row_total)
      else $error("carry-save tree lost value");
  end

endmodule

// File: rtl/booth_wmul.sv
module booth_wmul
  import booth_wmul_pkg::*;
#(
  parameter int XW    = 6,
  parameter int WW    = 6,
  parameter int RADIX = 8,
  parameter int TRUNC = 0,
  localparam int PW   = XW + WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] x_i,
  input  logic [WW-1:0] w_i,
  output logic          out_valid,
  output logic [PW-1:0] prod_o
);

  localparam int RB = (RADIX == 8) ? 3 : 2;
  localparam int ND = digit_count(WW, RB);
  localparam int NR = ND + 1;
  localparam logic [PW-1:0] BOUND = PW'(NR * ((1 << TRUNC) - 1));

  digit_t [ND-1:0]       digits;
  logic [NR-1:0][PW-1:0] rows;
  logic [PW-1:0]         tree_sum, tree_carry, cpa_sum;

  booth_wmul_recoder #(.WW(WW), .RADIX(RADIX)) rec_i (
    .w_i   (w_i),
    .dig_o (digits)
  );

  booth_wmul_ppgen #(.XW(XW), .PW(PW), .ND(ND), .RB(RB), .TRUNC(TRUNC)) pp_i (
    .x_i    (x_i),
    .dig_i  (digits),
    .rows_o (rows)
  );

  booth_wmul_csa_tree #(.PW(PW), .NR(NR)) tree_i (
    .rows_i  (rows),
    .sum_o   (tree_sum),
    .carry_o (tree_carry)
  );

  assign cpa_sum = tree_sum + tree_carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod_o    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod_o <= cpa_sum;
    end
  end

  // exact reference for the checks only
  logic signed [PW-1:0] ref_prod;
  assign ref_prod = $signed({{WW{x_i[XW-1]}}, x_i}) * $signed({{XW{w_i[WW-1]}}, w_i});

  always_comb begin
    if (rst_n && TRUNC == 0) begin
      // R4
      exact_prod_chk: assert (cpa_sum == ref_prod)
        else $error("product mismatch");
    end
    if (rst_n && TRUNC > 0) begin
      // R7
      trunc_bound_chk: assert (PW'(ref_prod - cpa_sum) <= BOUND)
        else $error("truncation error out of bound");
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(prod_o))
    else $error("product changed while idle");

  // R1
  reset_chk: assert property (@(posedge clk) $past(!rst_n) |-> (!out_valid && prod_o == '0))
    else $error("reset state wrong");

endmodule

// File: tb/booth_wmul_tb_top.sv
module booth_wmul_tb_top;

  localparam int XW  = 6;
  localparam int WW  = 6;
  localparam int PW  = XW + WW;
  localparam int K   = 3;
  localparam int BND = 3 * 7;   // (ceil(6/3)+1) * (2^3-1)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [XW-1:0] x_i = '0;
  logic [WW-1:0] w_i = '0;
  logic v8, v4, vt;
  logic [PW-1:0] p8, p4, pt;

  always #2 clk = ~clk;

  booth_wmul #(.XW(XW), .WW(WW), .RADIX(8), .TRUNC(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_i(x_i), .w_i(w_i),
    .out_valid(v8), .prod_o(p8));
  booth_wmul #(.XW(XW), .WW(WW), .RADIX(4), .TRUNC(0)) dut_r4_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_i(x_i), .w_i(w_i),
    .out_valid(v4), .prod_o(p4));
  booth_wmul #(.XW(XW), .WW(WW), .RADIX(8), .TRUNC(K)) dut_tr_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_i(x_i), .w_i(w_i),
    .out_valid(vt), .prod_o(pt));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  bit prev_v = 0;
  int prev_a = 0, prev_b = 0;
  logic [PW-1:0] held8 = '0, held4 = '0, heldt = '0;

  task automatic step(input bit v, input int a, input int b);
    int expv, d;
    @(negedge clk);
    if (prev_v) begin
      expv = prev_a * prev_b;
      chk(v8 && v4 && vt, "R2", {v8, v4, vt}, 7);
      chk($signed(p8) == expv, "R4", $signed(p8), expv);
      chk($signed(p4) == expv, "R5", $signed(p4), expv);
      if (prev_a == -32 || prev_b == -32 || prev_b == 31) begin
        chk($signed(p8) == expv && $signed(p4) == expv, "R6", $signed(p8), expv);
      end
      d = (expv - int'($signed(pt))) & ((1 << PW) - 1);
      chk(d >= 0 && d <= BND, "R7", d, BND);
      held8 = p8; held4 = p4; heldt = pt;
    end else begin
      chk(!v8 && !v4 && !vt, "R2", {v8, v4, vt}, 0);
      chk(p8 == held8 && p4 == held4 && pt == heldt, "R3", p8, held8);
    end
    in_valid = v;
    x_i = XW'(a);
    w_i = WW'(b);
    prev_v = v; prev_a = a; prev_b = b;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of all three configurations
    chk(!v8 && !v4 && !vt, "R1", {v8, v4, vt}, 0);
    chk(p8 == '0 && p4 == '0 && pt == '0, "R1", p8, 0);
    // operands offered during reset must not load
    in_valid = 1'b1; x_i = 6'd13; w_i = 6'd21;
    @(negedge clk);
    chk(!v8 && p8 == '0, "R1", p8, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int a = -32; a < 32; a++) begin
      for (int b = -32; b < 32; b++) begin
        step(1, a, b);
        if ((b & 15) == 7) step(0, a ^ 21, -b - 1);
      end
    end
    step(0, 5, -3);
    step(0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule